// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the always-on power sequencer of a small microcontroller. The CPU core signals its intent to sleep with a sleep-deep level and a one-cycle wait-for-interrupt or wait-for-event strobe. The controller combines that level with a standby-select bit it holds in its control register. The result picks one of three modes. Light sleep gates only the CPU clock. Deep-sleep stops every core-domain clock and the three clock sources, and may drop the regulator into low-power mode. Standby powers off the core domain and holds the core in reset.

On the way out of deep-sleep the controller walks through two timed stages. The first is a regulator settling stage, used only when the regulator was in low-power mode. The second is an oscillator start stage. After them it returns to run and pulses a strobe that forces the internal RC oscillator to be the system clock. Standby is left only through a power-on-reset style stage. That stage can be triggered by the external reset request, a synchronised rising edge on the wakeup pin (when enabled), an RTC alarm, or a watchdog reset. Core-domain control settings are lost in standby, while the wakeup and standby flags survive.

The controller also holds the backup-domain write-enable, the low-voltage detector enable and its 3-bit threshold. Software reaches these through a two-register interface: a control register and a status register.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode code `lpState` is 0 (run), every clock gate and power control is inactive, the three clock-source enables are high, both registers read 0, and `bkpWriteEn` is low.
- R2: A wait strobe (`wfiStrobe` or `wfeStrobe`) in run with `sleepDeep` low moves the block, on the next clock edge, to light sleep (code 1). There only `cpuClkGate` is high.
- R3: A light sleep entered by `wfiStrobe` ends only on `irqPending`, and one entered by `wfeStrobe` only on `evtPending`. The other input is ignored. The block is back in run (code 0) one clock edge after the wake input is seen.
- R4: A wait strobe with `sleepDeep` high and control bit 1 (standby select) clear enters deep-sleep (code 2). There both clock gates are high, `hsiEn`, `hseEn` and `pllEn` are low, and `ldoLowPower` equals control bit 0 as it stood at entry.
- R5: `extiWake` in deep-sleep starts the exit. If the regulator was in low-power mode, the block spends exactly LDO_WAKE_CYC cycles in code 3, with `ldoLowPower` low. It then spends exactly OSC_WAKE_CYC cycles in code 4 with only `hsiEn` high. It enters run with `forceHsi` high for that first cycle only. Without low-power mode, code 3 is skipped.
- R6: A wait strobe with `sleepDeep` high and control bit 1 set enters standby (code 5). There `corePwrOff` and `coreRstOut` are high, all clock sources are off, `lvdEnOut` is low, and status bit 1 (standby flag) is set.
- R7: In standby, `extRstReq`, `rtcAlarm`, `wdogRst` or an enabled wakeup-pin rising edge sets status bit 0 (wakeup flag). The block then spends exactly POR_CYC cycles in code 6 with `coreRstOut` high, and then returns to run with the control register reading 0. `extiWake` and `irqPending` are ignored in standby.
- R8: The wakeup pin counts only when status bit 8 (pin enable) is set. It passes a two-flop synchroniser and an edge detector, so a low-to-high change moves the block from standby to code 6 on the third clock edge. A pin already high, or a disabled pin, does not wake the block.
- R9: Writing 1 to control bit 2 clears status bit 0, and writing 1 to control bit 3 clears status bit 1. A clear bit is its flag's bit plus two. Writing 0 there has no effect, and both clear bits read back 0.
- R10: Control bits [7:5] drive `lvdThresh` and control bit 4 drives `lvdEnOut`. Status bit 2 reads `lvdBelow` while the detector is enabled and reads 0 while it is disabled.
- R11: Control bit 8 drives `bkpWriteEn`. Write access to the backup domain is off until software sets that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 control, 1 status |
| wrData | input | 9 | Write data |
| rdAddr | input | 1 | Read target: 0 control, 1 status |
| rdData | output | DW | Read data (combinational) |
| sleepDeep | input | 1 | CPU sleep-deep request level |
| wfiStrobe | input | 1 | CPU wait-for-interrupt strobe |
| wfeStrobe | input | 1 | CPU wait-for-event strobe |
| irqPending | input | 1 | Any interrupt pending |
| evtPending | input | 1 | Any event pending |
| extiWake | input | 1 | Any external interrupt or event line |
| wkupPin | input | 1 | Asynchronous wakeup pin, active high |
| extRstReq | input | 1 | Reset pin request |
| rtcAlarm | input | 1 | RTC alarm |
| wdogRst | input | 1 | Independent watchdog reset |
| lvdBelow | input | 1 | Low-voltage comparator output |
| lpState | output | 3 | Mode code (0 run … 6 power-on stage) |
| cpuClkGate | output | 1 | Gate CPU clock |
| coreClkGate | output | 1 | Gate all core-domain clocks |
| hsiEn | output | 1 | Internal RC oscillator enable |
| hseEn | output | 1 | External oscillator enable |
| pllEn | output | 1 | PLL enable |
| ldoLowPower | output | 1 | Regulator low-power mode |
| corePwrOff | output | 1 | Core-domain power off |
| coreRstOut | output | 1 | Core-domain reset |
| forceHsi | output | 1 | One-cycle strobe forcing internal RC as system clock |
| lvdEnOut | output | 1 | Voltage detector enable |
| lvdThresh | output | 3 | Voltage detector threshold |
| bkpWriteEn | output | 1 | Backup-domain write enable |

## Verification
The bench goes after the exit timing. A counter that was one off would show up as a settling or power-on stage one cycle too long or too short. A design that did not skip the regulator stage would show cycles in code 3 after a deep-sleep with the regulator on. It also checks that the wake input used by light sleep depends on the instruction: a block waking on either input would leave a wait-for-interrupt sleep on an event. In standby it drives non-standby wake inputs, a pin held high, a disabled pin and writes of zero to the clear bits, catching a level-sensitive pin detector or clear bits that act on any write. It also confirms that control settings vanish across standby while the two flags stay.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int REG_W          = 9;
  localparam int FLAG_CLR_SHIFT = 2;

  // status register bit positions
  localparam int STS_WUF  = 0;
  localparam int STS_SBF  = 1;
  localparam int STS_LVDF = 2;
  localparam int STS_WPEN = 8;

  // control register bit positions
  localparam int CTL_LDOLP  = 0;
  localparam int CTL_SBSEL  = 1;
  localparam int CTL_CLRWUF = STS_WUF + FLAG_CLR_SHIFT;
  localparam int CTL_CLRSBF = STS_SBF + FLAG_CLR_SHIFT;
  localparam int CTL_LVDEN  = 4;
  localparam int CTL_THR_LO = 5;
  localparam int THR_W      = 3;
  localparam int CTL_BKPWE  = 8;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_SLEEP    = 3'd1,
    ST_DEEP     = 3'd2,
    ST_WAKE_LDO = 3'd3,
    ST_WAKE_OSC = 3'd4,
    ST_STANDBY  = 3'd5,
    ST_POR      = 3'd6
  } lpm_state_e;

  typedef struct packed {
    logic setWuf;
    logic setSbf;
    logic clearCtrl;
    logic domainOff;
  } lpm_strb_t;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdAddr,
  output logic [DW-1:0]    rdData,
  input  logic             wkupPin,
  input  logic             extRstReq,
  input  logic             rtcAlarm,
  input  logic             wdogRst,
  input  logic             lvdBelow,
  input  lpm_strb_t        strb,
  output logic             standbySel,
  output logic             ldoLp,
  output logic             standbyWake,
  output logic             wufFlag,
  output logic             sbfFlag,
  output logic             lvdEnOut,
  output logic [THR_W-1:0] lvdThresh,
  output logic             bkpWriteEn
);

  logic             ldoLpQ, sbSelQ, lvdEnQ, bkpWeQ;
  logic [THR_W-1:0] thrQ;
  logic             wufQ, sbfQ, wpEnQ;
  logic             ctlWr, stsWr;

  assign ctlWr = wrEn && !strb.domainOff && (wrAddr == 1'b0);
  assign stsWr = wrEn && !strb.domainOff && (wrAddr == 1'b1);

  // core-domain control fields: lost while the domain is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldoLpQ <= 1'b0;
      sbSelQ <= 1'b0;
      lvdEnQ <= 1'b0;
      thrQ   <= '0;
      bkpWeQ <= 1'b0;
    end else if (strb.clearCtrl) begin
      ldoLpQ <= 1'b0;
      sbSelQ <= 1'b0;
      lvdEnQ <= 1'b0;
      thrQ   <= '0;
      bkpWeQ <= 1'b0;
    end else if (ctlWr) begin
      ldoLpQ <= wrData[CTL_LDOLP];
      sbSelQ <= wrData[CTL_SBSEL];
      lvdEnQ <= wrData[CTL_LVDEN];
      thrQ   <= wrData[CTL_THR_LO +: THR_W];
      bkpWeQ <= wrData[CTL_BKPWE];
    end
  end

  // always-on flags; a set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wufQ  <= 1'b0;
      sbfQ  <= 1'b0;
      wpEnQ <= 1'b0;
    end else begin
      if (strb.setWuf)                    wufQ <= 1'b1;
      else if (ctlWr && wrData[CTL_CLRWUF]) wufQ <= 1'b0;
      if (strb.setSbf)                    sbfQ <= 1'b1;
      else if (ctlWr && wrData[CTL_CLRSBF]) sbfQ <= 1'b0;
      if (stsWr)                          wpEnQ <= wrData[STS_WPEN];
    end
  end

  // wakeup pin synchroniser and rising-edge detector
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= wkupPin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  logic pinRise;
  assign pinRise     = syncQ[SYNC_STAGES-1] && !prevQ && wpEnQ;
  assign standbyWake = pinRise || extRstReq || rtcAlarm || wdogRst;

  assign standbySel = sbSelQ;
  assign ldoLp      = ldoLpQ;
  assign wufFlag    = wufQ;
  assign sbfFlag    = sbfQ;
  assign lvdEnOut   = lvdEnQ && !strb.domainOff;
  assign lvdThresh  = thrQ;
  assign bkpWriteEn = bkpWeQ;

  always_comb begin
    rdData = '0;
    if (rdAddr == 1'b0) begin
      rdData[CTL_LDOLP]            = ldoLpQ;
      rdData[CTL_SBSEL]            = sbSelQ;
      rdData[CTL_LVDEN]            = lvdEnQ;
      rdData[CTL_THR_LO +: THR_W]  = thrQ;
      rdData[CTL_BKPWE]            = bkpWeQ;
    end else begin
      rdData[STS_WUF]  = wufQ;
      rdData[STS_SBF]  = sbfQ;
      rdData[STS_LVDF] = lvdBelow && lvdEnOut;
      rdData[STS_WPEN] = wpEnQ;
    end
  end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int OSC_WAKE_CYC = 4,
  parameter int LDO_WAKE_CYC = 6,
  parameter int POR_CYC      = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepDeep,
  input  logic       wfiStrobe,
  input  logic       wfeStrobe,
  input  logic       irqPending,
  input  logic       evtPending,
  input  logic       extiWake,
  input  logic       standbySel,
  input  logic       ldoLp,
  input  logic       standbyWake,
  output lpm_strb_t  strb,
  output logic [2:0] lpState,
  output logic       cpuClkGate,
  output logic       coreClkGate,
  output logic       hsiEn,
  output logic       hseEn,
  output logic       pllEn,
  output logic       ldoLowPower,
  output logic       corePwrOff,
  output logic       coreRstOut,
  output logic       forceHsi
);

  localparam int MAX_A = (OSC_WAKE_CYC > LDO_WAKE_CYC) ? OSC_WAKE_CYC : LDO_WAKE_CYC;
  localparam int MAX_C = (MAX_A > POR_CYC) ? MAX_A : POR_CYC;
  localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);
  localparam logic [CW-1:0] OSC_LOAD = CW'(OSC_WAKE_CYC - 1);
  localparam logic [CW-1:0] LDO_LOAD = CW'(LDO_WAKE_CYC - 1);
  localparam logic [CW-1:0] POR_LOAD = CW'(POR_CYC - 1);

  lpm_state_e    state, nextState;
  logic [CW-1:0] cnt;
  logic          viaWfe, ldoLpLat, forceQ;
  logic          waitReq, sleepWake, cntDone;

  assign waitReq   = wfiStrobe || wfeStrobe;
  assign sleepWake = viaWfe ? evtPending : irqPending;
  assign cntDone   = (cnt == '0);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN: begin
        if (waitReq) begin
          if (!sleepDeep)      nextState = ST_SLEEP;
          else if (standbySel) nextState = ST_STANDBY;
          else                 nextState = ST_DEEP;
        end
      end
      ST_SLEEP:    if (sleepWake)   nextState = ST_RUN;
      ST_DEEP:     if (extiWake)    nextState = ldoLpLat ? ST_WAKE_LDO : ST_WAKE_OSC;
      ST_WAKE_LDO: if (cntDone)     nextState = ST_WAKE_OSC;
      ST_WAKE_OSC: if (cntDone)     nextState = ST_RUN;
      ST_STANDBY:  if (standbyWake) nextState = ST_POR;
      ST_POR:      if (cntDone)     nextState = ST_RUN;
      default:                      nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      cnt      <= '0;
      viaWfe   <= 1'b0;
      ldoLpLat <= 1'b0;
      forceQ   <= 1'b0;
    end else begin
      state  <= nextState;
      forceQ <= (state == ST_WAKE_OSC) && (nextState == ST_RUN);
      if (state == ST_RUN && waitReq) begin
        viaWfe   <= wfeStrobe && !wfiStrobe;
        ldoLpLat <= ldoLp;
      end
      if (nextState != state) begin
        case (nextState)
          ST_WAKE_LDO: cnt <= LDO_LOAD;
          ST_WAKE_OSC: cnt <= OSC_LOAD;
          ST_POR:      cnt <= POR_LOAD;
          default:     cnt <= '0;
        endcase
      end else if (!cntDone) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_comb begin
    strb.setSbf    = (state == ST_RUN) && (nextState == ST_STANDBY);
    strb.setWuf    = (state == ST_STANDBY) && (nextState == ST_POR);
    strb.clearCtrl = (state == ST_STANDBY);
    strb.domainOff = (state == ST_STANDBY);
  end

  always_comb begin
    cpuClkGate  = 1'b1;
    coreClkGate = 1'b1;
    hsiEn       = 1'b0;
    hseEn       = 1'b0;
    pllEn       = 1'b0;
    ldoLowPower = 1'b0;
    corePwrOff  = 1'b0;
    coreRstOut  = 1'b0;
    unique case (state)
      ST_RUN: begin
        cpuClkGate  = 1'b0;
        coreClkGate = 1'b0;
        hsiEn = 1'b1; hseEn = 1'b1; pllEn = 1'b1;
      end
      ST_SLEEP: begin
        coreClkGate = 1'b0;
        hsiEn = 1'b1; hseEn = 1'b1; pllEn = 1'b1;
      end
      ST_DEEP:     ldoLowPower = ldoLpLat;
      ST_WAKE_LDO: ;
      ST_WAKE_OSC: hsiEn = 1'b1;
      ST_STANDBY: begin
        corePwrOff = 1'b1;
        coreRstOut = 1'b1;
      end
      ST_POR: begin
        hsiEn      = 1'b1;
        coreRstOut = 1'b1;
      end
      default: ;
    endcase
  end

  assign lpState  = state;
  assign forceHsi = forceQ;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DW           = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int OSC_WAKE_CYC = 4,
  parameter int LDO_WAKE_CYC = 6,
  parameter int POR_CYC      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdAddr,
  output logic [DW-1:0]    rdData,
  input  logic             sleepDeep,
  input  logic             wfiStrobe,
  input  logic             wfeStrobe,
  input  logic             irqPending,
  input  logic             evtPending,
  input  logic             extiWake,
  input  logic             wkupPin,
  input  logic             extRstReq,
  input  logic             rtcAlarm,
  input  logic             wdogRst,
  input  logic             lvdBelow,
  output logic [2:0]       lpState,
  output logic             cpuClkGate,
  output logic             coreClkGate,
  output logic             hsiEn,
  output logic             hseEn,
  output logic             pllEn,
  output logic             ldoLowPower,
  output logic             corePwrOff,
  output logic             coreRstOut,
  output logic             forceHsi,
  output logic             lvdEnOut,
  output logic [THR_W-1:0] lvdThresh,
  output logic             bkpWriteEn
);

  lpm_strb_t strb;
  logic      standbySel, ldoLp, standbyWake, wufFlag, sbfFlag;

  lpm_regs #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .wkupPin(wkupPin), .extRstReq(extRstReq), .rtcAlarm(rtcAlarm),
    .wdogRst(wdogRst), .lvdBelow(lvdBelow), .strb(strb),
    .standbySel(standbySel), .ldoLp(ldoLp), .standbyWake(standbyWake),
    .wufFlag(wufFlag), .sbfFlag(sbfFlag),
    .lvdEnOut(lvdEnOut), .lvdThresh(lvdThresh), .bkpWriteEn(bkpWriteEn)
  );

  lpm_seq #(
    .OSC_WAKE_CYC(OSC_WAKE_CYC), .LDO_WAKE_CYC(LDO_WAKE_CYC), .POR_CYC(POR_CYC)
  ) u_seq (
    .clk(clk), .rstN(rstN),
    .sleepDeep(sleepDeep), .wfiStrobe(wfiStrobe), .wfeStrobe(wfeStrobe),
    .irqPending(irqPending), .evtPending(evtPending), .extiWake(extiWake),
    .standbySel(standbySel), .ldoLp(ldoLp), .standbyWake(standbyWake),
    .strb(strb), .lpState(lpState),
    .cpuClkGate(cpuClkGate), .coreClkGate(coreClkGate),
    .hsiEn(hsiEn), .hseEn(hseEn), .pllEn(pllEn),
    .ldoLowPower(ldoLowPower), .corePwrOff(corePwrOff),
    .coreRstOut(coreRstOut), .forceHsi(forceHsi)
  );

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int OSC_WAKE_CYC = 4,
  parameter int POR_CYC      = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] lpState,
  input logic       cpuClkGate,
  input logic       coreClkGate,
  input logic       hsiEn,
  input logic       hseEn,
  input logic       pllEn,
  input logic       corePwrOff,
  input logic       coreRstOut,
  input logic       lvdEnOut,
  input logic       forceHsi,
  input logic       irqPending,
  input logic       evtPending,
  input logic       wufFlag,
  input logic       sbfFlag
);

  logic [31:0] oscRun, porRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscRun <= '0;
      porRun <= '0;
    end else begin
      oscRun <= (lpState == ST_WAKE_OSC) ? oscRun + 32'd1 : 32'd0;
      porRun <= (lpState == ST_POR)      ? porRun + 32'd1 : 32'd0;
    end
  end

  // R2: light sleep gates only the CPU clock
  p_sleep_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == ST_SLEEP) |-> (cpuClkGate && !coreClkGate));

  // R3: no wake input, no exit from light sleep
  p_sleep_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == ST_SLEEP && !irqPending && !evtPending) |=> (lpState == ST_SLEEP));

  // R4: deep-sleep stops all sources and core clocks
  p_deep_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == ST_DEEP) |-> (!hsiEn && !hseEn && !pllEn && coreClkGate));

  // R5: oscillator stage never outlasts its count
  p_osc_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == ST_WAKE_OSC) |-> (oscRun < OSC_WAKE_CYC));

  // R5: clock-select strobe only on the first run cycle after the oscillator stage
  p_force_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    forceHsi |-> (lpState == ST_RUN && $past(lpState) == ST_WAKE_OSC));

  // R6: domain off implies reset held, detector stopped, flag recorded
  p_standby_pwr_r6: assert property (@(posedge clk) disable iff (!rstN)
    corePwrOff |-> (coreRstOut && !lvdEnOut && sbfFlag));

  // R7: leaving standby records the wakeup flag
  p_wuf_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == ST_POR && $past(lpState) == ST_STANDBY) |-> wufFlag);

  // R7: power-on stage bounded and exits to run
  p_por_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == ST_POR) |-> (porRun < POR_CYC && coreRstOut));

  p_por_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lpState) == ST_POR && lpState != ST_POR) |-> (lpState == ST_RUN));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.OSC_WAKE_CYC(OSC_WAKE_CYC), .POR_CYC(POR_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .lpState(lpState),
  .cpuClkGate(cpuClkGate), .coreClkGate(coreClkGate),
  .hsiEn(hsiEn), .hseEn(hseEn), .pllEn(pllEn),
  .corePwrOff(corePwrOff), .coreRstOut(coreRstOut), .lvdEnOut(lvdEnOut),
  .forceHsi(forceHsi), .irqPending(irqPending), .evtPending(evtPending),
  .wufFlag(wufFlag), .sbfFlag(sbfFlag)
);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;

  localparam int DW  = 32;
  localparam int OSC = 4;
  localparam int LDO = 6;
  localparam int POR = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 0, wrAddr = 0, rdAddr = 0;
  logic [8:0]    wrData = '0;
  logic [DW-1:0] rdData;
  logic sleepDeep = 0, wfiStrobe = 0, wfeStrobe = 0;
  logic irqPending = 0, evtPending = 0, extiWake = 0;
  logic wkupPin = 0, extRstReq = 0, rtcAlarm = 0, wdogRst = 0, lvdBelow = 0;
  logic [2:0] lpState, lvdThresh;
  logic cpuClkGate, coreClkGate, hsiEn, hseEn, pllEn, ldoLowPower;
  logic corePwrOff, coreRstOut, forceHsi, lvdEnOut, bkpWriteEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpm_ctrl #(.DW(DW), .OSC_WAKE_CYC(OSC), .LDO_WAKE_CYC(LDO), .POR_CYC(POR)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sleepDeep(sleepDeep),
    .wfiStrobe(wfiStrobe), .wfeStrobe(wfeStrobe), .irqPending(irqPending),
    .evtPending(evtPending), .extiWake(extiWake), .wkupPin(wkupPin),
    .extRstReq(extRstReq), .rtcAlarm(rtcAlarm), .wdogRst(wdogRst),
    .lvdBelow(lvdBelow), .lpState(lpState), .cpuClkGate(cpuClkGate),
    .coreClkGate(coreClkGate), .hsiEn(hsiEn), .hseEn(hseEn), .pllEn(pllEn),
    .ldoLowPower(ldoLowPower), .corePwrOff(corePwrOff), .coreRstOut(coreRstOut),
    .forceHsi(forceHsi), .lvdEnOut(lvdEnOut), .lvdThresh(lvdThresh),
    .bkpWriteEn(bkpWriteEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [8:0] data);
    wrEn = 1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 0; wrData = '0;
  endtask

  task automatic rd(input logic addr, output logic [31:0] data);
    rdAddr = addr;
    #1;
    data = rdData;
  endtask

  task automatic enter(input logic deep, input logic useWfe);
    sleepDeep = deep; wfiStrobe = !useWfe; wfeStrobe = useWfe;
    @(negedge clk);
    wfiStrobe = 0; wfeStrobe = 0; sleepDeep = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1;
    @(negedge clk);
    sig = 0;
  endtask

  task automatic porRun(input string tag);
    int n = 0;
    bit rstOk = 1;
    while (lpState == 3'd6 && n < 50) begin
      if (!coreRstOut) rstOk = 0;
      n++;
      @(negedge clk);
    end
    chk({tag, " power-on stage length"}, n, POR);
    chk({tag, " reset held in power-on stage"}, rstOk, 1);
    chk({tag, " back in run"}, lpState, 0);
  endtask

  task automatic tReset();
    logic [31:0] v;
    chk("R1 reset state", lpState, 0);
    chk("R1 reset gates", {cpuClkGate, coreClkGate, corePwrOff, coreRstOut, ldoLowPower}, 0);
    chk("R1 reset sources", {hsiEn, hseEn, pllEn}, 3'b111);
    chk("R1 backup write off", bkpWriteEn, 0);
    rd(0, v); chk("R1 control reads 0", v, 0);
    rd(1, v); chk("R1 status reads 0", v, 0);
  endtask

  task automatic tSleepWfi();
    enter(0, 0);
    chk("R2 wfi sleep state", lpState, 1);
    chk("R2 only cpu gated", {cpuClkGate, coreClkGate, hsiEn, hseEn, pllEn}, 5'b10111);
    evtPending = 1;
    repeat (3) @(negedge clk);
    chk("R3 event ignored in wfi sleep", lpState, 1);
    evtPending = 0; irqPending = 1;
    @(negedge clk);
    irqPending = 0;
    chk("R3 irq wakes wfi sleep", lpState, 0);
  endtask

  task automatic tSleepWfe();
    enter(0, 1);
    chk("R2 wfe sleep state", lpState, 1);
    irqPending = 1;
    repeat (3) @(negedge clk);
    chk("R3 irq ignored in wfe sleep", lpState, 1);
    irqPending = 0; evtPending = 1;
    @(negedge clk);
    evtPending = 0;
    chk("R3 event wakes wfe sleep", lpState, 0);
  endtask

  task automatic tDeep(input bit lp);
    int nL = 0, nO = 0;
    bit ldoLowInWake = 1;
    wr(0, {8'd0, lp});
    enter(1, 0);
    chk("R4 deep state", lpState, 2);
    chk("R4 deep sources off", {hsiEn, hseEn, pllEn}, 0);
    chk("R4 deep clocks gated", {cpuClkGate, coreClkGate}, 2'b11);
    chk("R4 regulator mode", ldoLowPower, lp);
    pulse(extiWake);
    while (lpState != 3'd0 && (nL + nO) < 60) begin
      if (lpState == 3'd3) begin nL++; if (ldoLowPower) ldoLowInWake = 0; end
      else if (lpState == 3'd4) begin
        nO++;
        chk("R5 osc stage only internal RC", {hsiEn, hseEn, pllEn}, 3'b100);
      end
      @(negedge clk);
    end
    chk("R5 regulator stage length", nL, lp ? LDO : 0);
    chk("R5 regulator normal while settling", ldoLowInWake, 1);
    chk("R5 osc stage length", nO, OSC);
    chk("R5 clock-select strobe", forceHsi, 1);
    @(negedge clk);
    chk("R5 clock-select strobe one cycle", forceHsi, 0);
  endtask

  task automatic tStandbyRtc();
    logic [31:0] v;
    wr(0, 9'h1F2);
    chk("R11 backup write enabled", bkpWriteEn, 1);
    chk("R10 threshold field", lvdThresh, 7);
    chk("R10 detector enabled", lvdEnOut, 1);
    enter(1, 0);
    chk("R6 standby state", lpState, 5);
    chk("R6 standby power", {corePwrOff, coreRstOut, hsiEn, hseEn, pllEn}, 5'b11000);
    chk("R6 detector stopped", lvdEnOut, 0);
    rd(1, v); chk("R6 standby flag set", v[1:0], 2'b10);
    extiWake = 1; irqPending = 1;
    repeat (3) @(negedge clk);
    extiWake = 0; irqPending = 0;
    chk("R7 non-standby wakes ignored", lpState, 5);
    pulse(rtcAlarm);
    chk("R7 rtc alarm starts power-on", lpState, 6);
    porRun("R7 rtc");
    rd(0, v); chk("R7 control lost", v, 0);
    rd(1, v); chk("R7 flags kept", v[1:0], 2'b11);
    chk("R11 backup write lost", bkpWriteEn, 0);
  endtask

  task automatic tFlagClear();
    logic [31:0] v;
    wr(0, 9'h004);
    rd(1, v); chk("R9 wakeup flag cleared", v[1:0], 2'b10);
    wr(0, 9'h000);
    rd(1, v); chk("R9 zero write no effect", v[1:0], 2'b10);
    wr(0, 9'h008);
    rd(1, v); chk("R9 standby flag cleared", v[1:0], 2'b00);
    wr(0, 9'h00C);
    rd(0, v); chk("R9 clear bits read 0", v, 0);
  endtask

  task automatic tPin();
    logic [31:0] v;
    int n = 0;
    wr(1, 9'h100);
    rd(1, v); chk("R8 pin enable reads back", v[8], 1);
    wr(0, 9'h002);
    enter(1, 0);
    wkupPin = 1;
    while (lpState == 3'd5 && n < 10) begin @(negedge clk); n++; end
    chk("R8 pin edge latency", n, 3);
    chk("R7 pin edge starts power-on", lpState, 6);
    porRun("R7 pin");
    rd(1, v); chk("R7 pin sets wakeup flag", v[0], 1);
    wr(0, 9'h00E);
    enter(1, 0);
    repeat (8) @(negedge clk);
    chk("R8 held-high pin no wake", lpState, 5);
    rd(1, v); chk("R8 held pin no flag", v[0], 0);
    wkupPin = 0;
    repeat (3) @(negedge clk);
    pulse(extRstReq);
    chk("R7 reset request starts power-on", lpState, 6);
    porRun("R7 reset req");
    wr(1, 9'h000);
    wr(0, 9'h002);
    enter(1, 0);
    wkupPin = 1;
    repeat (6) @(negedge clk);
    chk("R8 disabled pin ignored", lpState, 5);
    wkupPin = 0;
    pulse(wdogRst);
    chk("R7 watchdog starts power-on", lpState, 6);
    porRun("R7 watchdog");
  endtask

  task automatic tLvdBkp();
    logic [31:0] v;
    lvdBelow = 1;
    wr(0, 9'h0B0);
    chk("R10 threshold 5", lvdThresh, 5);
    rd(1, v); chk("R10 below flag enabled", v[2], 1);
    wr(0, 9'h0A0);
    chk("R10 detector off", lvdEnOut, 0);
    rd(1, v); chk("R10 flag masked when off", v[2], 0);
    lvdBelow = 0;
    wr(0, 9'h100);
    chk("R11 backup set", bkpWriteEn, 1);
    wr(0, 9'h000);
    chk("R11 backup cleared", bkpWriteEn, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tSleepWfi();
    tSleepWfe();
    tDeep(0);
    tDeep(1);
    tStandbyRtc();
    tFlagClear();
    tPin();
    tLvdBkp();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule